// File: doc/BRIEF.md
# Five-Stage Integer Pipeline

This block is a 32-bit load-store integer core split into five stages: fetch, decode with register read, execute, memory access and write-back. Each pair of neighbouring stages is separated by a bank of pipeline registers. The core has thirty-two general registers. Register 0 always reads as zero. The core supports register-register and register-immediate arithmetic and logic, word loads and stores, and two branches that test a register against zero.

Instruction memory and data memory are separate ports, and each answers within the same cycle. The core has no operand forwarding, no interlock and no flush. Software must place enough independent words or NOPs between a producer and its consumer, and after every branch. The all-zero word is a NOP. Reset fills every pipeline register with that NOP and sets the program counter to 0.

Instruction fields: the opcode is bits 31:26. The first source is bits 25:21. The second source (and the destination of immediate forms and loads) is bits 20:16. The register-register destination is bits 15:11. The function code is bits 5:0. The immediate is bits 15:0, sign-extended from bit 15.

Top module: `int_pipe5`

## Requirements
- R1: While reset is asserted, `imem_addr` is 0 and `dmem_we` is 0. After release, every stage holds a NOP, so the first store word fetched from address 0 drives `dmem_we` high only after three rising edges.
- R2: When no branch is taken, `imem_addr` advances by 4 on every rising edge.
- R3: Opcode 0x00 selects a register-register operation on the first and second sources, and the result is written to bits 15:11. The function codes are: 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 XOR, 5 signed less-than (writes 1 or 0).
- R4: Opcodes 0x08 to 0x0D apply add, subtract, AND, OR, XOR and signed less-than to the first source and the sign-extended immediate. The result is written to the register named by bits 20:16.
- R5: Opcode 0x23 loads the word at first source + immediate into the register named by bits 20:16. Opcode 0x2B stores the register named by bits 20:16 to first source + immediate, and asserts `dmem_we` for one cycle.
- R6: Opcode 0x04 branches when the tested register (bits 25:21) is zero, and opcode 0x05 branches when it is nonzero. The target is the branch address + 4 + immediate. The three words after a branch always execute.
- R7: Register 0 reads as zero, and any write to it is discarded.
- R8: A register read in decode during the same cycle that write-back updates it returns the old value. A consumer placed four or more words after its producer sees the new value.
- R9: An undefined opcode, or opcode 0x00 with a function code above 5, writes no register and performs no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch byte address (the program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data byte address computed for the instruction in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The branch test places distinct register writes in each of the three following slots, at the words just before and after the expected target, and behind both not-taken forms. A core that flushed the following slots, computed the target from the branch's own address, or inverted a condition would leave a different pattern of stored values.

A separate program spaces a consumer only three words after its producer. A core that bypassed the register file during write-back would store the new value instead of the stale zero. Writes aimed at register 0 are checked, and so are signed comparisons between negative and positive operands and negative immediates. Undefined encodings are given operands that would leave a visible nonzero result if they were wrongly committed.

// File: rtl/int_pipe5.sv
module int_pipe5 (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_IMLO = 6'h08;
  localparam logic [5:0] OP_IMHI = 6'h0D;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  logic [31:0] pc;
  logic [31:0] ifid_ir, ifid_npc;
  logic [31:0] idex_ir, idex_npc, idex_a, idex_b, idex_imm;
  logic [31:0] exmem_ir, exmem_alu, exmem_b;
  logic        exmem_cond;
  logic [31:0] memwb_ir, memwb_alu, memwb_lmd;
  logic [31:0] regs [32];

  // fetch
  logic [31:0] pc_next;
  assign pc_next   = exmem_cond ? exmem_alu : pc + 32'd4;
  assign imem_addr = pc;

  // execute
  logic [5:0]  ex_op;
  logic        ex_rr, ex_imm, ex_br, ex_cond;
  logic [31:0] ex_y, ex_alu, ex_res;
  logic [2:0]  ex_sel;
  assign ex_op  = idex_ir[31:26];
  assign ex_rr  = ex_op == OP_RR;
  assign ex_imm = ex_op >= OP_IMLO && ex_op <= OP_IMHI;
  assign ex_br  = ex_op == OP_BEQZ || ex_op == OP_BNEZ;
  assign ex_y   = ex_rr ? idex_b : idex_imm;
  assign ex_sel = ex_rr ? idex_ir[2:0] : ex_op[2:0];

  always_comb begin
    case (ex_sel)
      3'd1:    ex_alu = idex_a - ex_y;
      3'd2:    ex_alu = idex_a & ex_y;
      3'd3:    ex_alu = idex_a | ex_y;
      3'd4:    ex_alu = idex_a ^ ex_y;
      3'd5:    ex_alu = {31'd0, $signed(idex_a) < $signed(ex_y)};
      default: ex_alu = idex_a + ex_y;
    endcase
  end

  assign ex_res  = (ex_rr || ex_imm) ? ex_alu :
                   ex_br ? idex_npc + idex_imm : idex_a + idex_imm;
  assign ex_cond = (ex_op == OP_BEQZ && idex_a == 32'd0) ||
                   (ex_op == OP_BNEZ && idex_a != 32'd0);

  // memory
  assign dmem_addr  = exmem_alu;
  assign dmem_wdata = exmem_b;
  assign dmem_we    = exmem_ir[31:26] == OP_SW;

  // write-back
  logic [5:0]  wb_op;
  logic        wb_we;
  logic [4:0]  wb_dst;
  logic [31:0] wb_data;
  assign wb_op   = memwb_ir[31:26];
  assign wb_we   = (wb_op == OP_RR && memwb_ir[5:0] <= 6'd5) ||
                   (wb_op >= OP_IMLO && wb_op <= OP_IMHI) || wb_op == OP_LW;
  assign wb_dst  = (wb_op == OP_RR) ? memwb_ir[15:11] : memwb_ir[20:16];
  assign wb_data = (wb_op == OP_LW) ? memwb_lmd : memwb_alu;

  logic unused_fields;
  assign unused_fields = ^{memwb_ir[25:21], memwb_ir[10:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      ifid_ir    <= '0;
      ifid_npc   <= '0;
      idex_ir    <= '0;
      idex_npc   <= '0;
      idex_a     <= '0;
      idex_b     <= '0;
      idex_imm   <= '0;
      exmem_ir   <= '0;
      exmem_alu  <= '0;
      exmem_b    <= '0;
      exmem_cond <= 1'b0;
      memwb_ir   <= '0;
      memwb_alu  <= '0;
      memwb_lmd  <= '0;
      for (int i = 0; i < 32; i++) regs[i] <= '0;
    end else begin
      pc         <= pc_next;
      ifid_ir    <= imem_rdata;
      ifid_npc   <= pc_next;
      idex_ir    <= ifid_ir;
      idex_npc   <= ifid_npc;
      idex_a     <= regs[ifid_ir[25:21]];
      idex_b     <= regs[ifid_ir[20:16]];
      idex_imm   <= {{16{ifid_ir[15]}}, ifid_ir[15:0]};
      exmem_ir   <= idex_ir;
      exmem_alu  <= ex_res;
      exmem_b    <= idex_b;
      exmem_cond <= ex_cond;
      memwb_ir   <= exmem_ir;
      memwb_alu  <= exmem_alu;
      memwb_lmd  <= dmem_rdata;
      if (wb_we && wb_dst != 5'd0) regs[wb_dst] <= wb_data;
    end
  end

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exmem_cond |=> pc == $past(pc) + 32'd4);
  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_cond |=> (pc == $past(exmem_alu) && ifid_npc == pc));
  p_cond_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_cond |-> (exmem_ir[31:26] == OP_BEQZ || exmem_ir[31:26] == OP_BNEZ));
  p_store_no_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !exmem_cond);
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == 32'd0);
  p_wb_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_dst != 5'd0) |=> regs[$past(wb_dst)] == $past(wb_data));
endmodule

// File: tb/int_pipe5_bench.sv
`timescale 1ns/1ps
module int_pipe5_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int errors = 0;
  int checks = 0;
  int wp = 0;
  logic [31:0] im [64];
  logic [31:0] dm [64];

  always #4 clk = ~clk;

  int_pipe5 u_int_pipe5 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = (imem_addr[31:8] == 24'd0) ? im[imem_addr[7:2]] : 32'd0;
  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [4:0] s1, input logic [4:0] s2,
                                        input logic [4:0] d, input logic [5:0] f);
    return {6'h00, s1, s2, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s1,
                                        input logic [4:0] d, input logic [15:0] imm);
    return {op, s1, d, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin im[i] = 32'd0; dm[i] = 32'd0; end
    wp = 0;
  endtask
  task automatic put(input logic [31:0] w); im[wp] = w; wp++; endtask
  task automatic nops(input int n); for (int i = 0; i < n; i++) put(32'd0); endtask
  task automatic reset_dut();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask
  task automatic run(input int n); repeat (n) @(negedge clk); endtask

  task automatic t_reset();
    clear_all();
    for (int i = 0; i < 8; i++) im[i] = enc_i(6'h2B, 5'd0, 5'd0, 16'h0);
    @(negedge clk); rst_n = 1'b0;
    run(2);
    chk("R1 pc in reset", imem_addr, 32'd0);
    chk("R1 we in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R1 we while nops drain", {31'd0, dmem_we}, 32'd0);
      run(1);
    end
    chk("R1 first store reaches memory", {31'd0, dmem_we}, 32'd1);
  endtask

  task automatic t_seq();
    clear_all();
    reset_dut();
    for (int k = 0; k < 4; k++) begin
      chk("R2 sequential pc", imem_addr, 32'(4 * k));
      run(1);
    end
  endtask

  task automatic t_rr();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd1, 16'd7));
    put(enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD));
    nops(3);
    put(enc_r(5'd1, 5'd2, 5'd3, 6'd0));
    put(enc_r(5'd1, 5'd2, 5'd4, 6'd1));
    put(enc_r(5'd1, 5'd2, 5'd5, 6'd2));
    put(enc_r(5'd1, 5'd2, 5'd6, 6'd3));
    put(enc_r(5'd1, 5'd2, 5'd7, 6'd4));
    put(enc_r(5'd2, 5'd1, 5'd8, 6'd5));
    put(enc_r(5'd1, 5'd2, 5'd9, 6'd5));
    nops(3);
    for (int r = 3; r <= 9; r++) put(enc_i(6'h2B, 5'd0, 5'(r), 16'(4 * (r - 3))));
    reset_dut();
    run(60);
    chk("R3 add", dm[0], 32'd4);
    chk("R3 sub", dm[1], 32'd10);
    chk("R3 and", dm[2], 32'd5);
    chk("R3 or", dm[3], 32'hFFFFFFFF);
    chk("R3 xor", dm[4], 32'hFFFFFFFA);
    chk("R3 slt neg<pos", dm[5], 32'd1);
    chk("R3 slt pos<neg", dm[6], 32'd0);
  endtask

  task automatic t_imm();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd1, 16'h1234));
    nops(3);
    put(enc_i(6'h09, 5'd1, 5'd2, 16'h0001));
    put(enc_i(6'h0A, 5'd1, 5'd3, 16'h00F0));
    put(enc_i(6'h0B, 5'd1, 5'd4, 16'h8000));
    put(enc_i(6'h0C, 5'd1, 5'd5, 16'hFFFF));
    put(enc_i(6'h0D, 5'd1, 5'd6, 16'h2000));
    nops(3);
    for (int r = 2; r <= 6; r++) put(enc_i(6'h2B, 5'd0, 5'(r), 16'(4 * (r - 2))));
    reset_dut();
    run(50);
    chk("R4 subi", dm[0], 32'h00001233);
    chk("R4 andi", dm[1], 32'h00000030);
    chk("R4 ori sign-extended", dm[2], 32'hFFFF9234);
    chk("R4 xori", dm[3], 32'hFFFFEDCB);
    chk("R4 slti", dm[4], 32'd1);
  endtask

  task automatic t_mem();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd1, 16'h0040));
    put(enc_i(6'h08, 5'd0, 5'd2, 16'h0055));
    nops(3);
    put(enc_i(6'h2B, 5'd1, 5'd2, 16'h0008));
    put(enc_i(6'h23, 5'd1, 5'd3, 16'hFFF0));
    nops(3);
    put(enc_i(6'h2B, 5'd0, 5'd3, 16'h0000));
    reset_dut();
    dm[12] = 32'hCAFEF00D;
    run(40);
    chk("R5 store base+offset", dm[18], 32'h00000055);
    chk("R5 load negative offset", dm[0], 32'hCAFEF00D);
  endtask

  task automatic t_branch();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd2, 16'd1));
    nops(3);
    put(enc_i(6'h04, 5'd0, 5'd0, 16'h0020));
    put(enc_i(6'h08, 5'd0, 5'd3, 16'h0011));
    put(enc_i(6'h08, 5'd0, 5'd4, 16'h0022));
    put(enc_i(6'h08, 5'd0, 5'd5, 16'h0033));
    for (int i = 0; i < 5; i++) put(enc_i(6'h08, 5'd0, 5'd6, 16'h0044));
    put(enc_i(6'h05, 5'd2, 5'd0, 16'h0010));
    nops(3);
    put(enc_i(6'h08, 5'd0, 5'd7, 16'h0077));
    put(enc_i(6'h04, 5'd2, 5'd0, 16'h0040));
    nops(3);
    put(enc_i(6'h08, 5'd0, 5'd8, 16'h0088));
    put(enc_i(6'h05, 5'd0, 5'd0, 16'h0040));
    nops(6);
    for (int r = 3; r <= 8; r++) put(enc_i(6'h2B, 5'd0, 5'(r), 16'(4 * (r - 3))));
    reset_dut();
    run(70);
    chk("R6 slot 1 executes", dm[0], 32'h11);
    chk("R6 slot 2 executes", dm[1], 32'h22);
    chk("R6 slot 3 executes", dm[2], 32'h33);
    chk("R6 beqz taken skips", dm[3], 32'h0);
    chk("R6 bnez taken target", dm[4], 32'h0);
    chk("R6 not-taken falls through", dm[5], 32'h88);
  endtask

  task automatic t_r0();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd0, 16'h0099));
    put(enc_i(6'h23, 5'd0, 5'd0, 16'h0020));
    nops(3);
    put(enc_i(6'h2B, 5'd0, 5'd0, 16'h0010));
    put(enc_i(6'h08, 5'd0, 5'd1, 16'h0000));
    reset_dut();
    dm[8] = 32'h12345678;
    run(30);
    chk("R7 write to r0 discarded", dm[4], 32'd0);
    chk("R7 load source intact", dm[8], 32'h12345678);
  endtask

  task automatic t_nobypass();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd1, 16'd5));
    nops(2);
    put(enc_i(6'h2B, 5'd0, 5'd1, 16'h0000));
    put(enc_i(6'h08, 5'd0, 5'd2, 16'd6));
    nops(3);
    put(enc_i(6'h2B, 5'd0, 5'd2, 16'h0004));
    put(enc_i(6'h2B, 5'd0, 5'd1, 16'h0008));
    reset_dut();
    run(30);
    chk("R8 same-cycle read is stale", dm[0], 32'd0);
    chk("R8 four apart sees new", dm[1], 32'd6);
    chk("R8 later read sees value", dm[2], 32'd5);
  endtask

  task automatic t_unknown();
    clear_all();
    put(enc_i(6'h08, 5'd0, 5'd1, 16'h0010));
    nops(3);
    put(enc_i(6'h3F, 5'd1, 5'd2, 16'h0005));
    put(enc_r(5'd1, 5'd1, 5'd3, 6'd7));
    put(enc_i(6'h2A, 5'd1, 5'd1, 16'h0000));
    nops(3);
    put(enc_i(6'h2B, 5'd0, 5'd2, 16'h0000));
    put(enc_i(6'h2B, 5'd0, 5'd3, 16'h0004));
    reset_dut();
    run(30);
    chk("R9 undefined opcode no write", dm[0], 32'd0);
    chk("R9 undefined func no write", dm[1], 32'd0);
    chk("R9 undefined opcode no store", dm[4], 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_rr();
    t_imm();
    t_mem();
    t_branch();
    t_r0();
    t_nobypass();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule